// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for each beat of one read or write burst of a two-bank SDRAM whose rows hold 256 columns. A mode-key write programs the burst length, the ordering (linear with wrap inside the aligned group, or XOR-interleaved), the read latency and a single-beat write option. The mode key is decoded and checked, and a key carrying a reserved code is refused. Once a read or write strobe arrives, the block presents the start column in the next cycle. It then steps through the burst, flags the final beat and stops by itself. The only exception is full-page mode, where it wraps around the row until a stop or a new command ends it.

For read bursts a data-valid flag trails the beats by the programmed latency, counted from the command cycle. A read output-mask pipeline with a fixed depth of two cycles is also provided. A write-strobe output combines active write beats with the write mask in the same cycle.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset no burst is active, `mode_err`, `rd_dvalid` and `rd_hiz` are 0, and the mode is burst length 1, linear order, latency 2, full-length writes.
- R2: On `mode_wr`, key bits [2:0] select the burst length: 0→1, 1→2, 2→4, 3→8, 7→full page. The new mode applies to the next command, and a burst in progress keeps the mode it started with.
- R3: With key bit 3 = 0, beats run linearly from the start column and wrap inside the length-aligned group (length 4 from column 2: 2,3,0,1).
- R4: With key bit 3 = 1, beat n has column start XOR n (length 8 from 5: 5,4,7,6,1,0,3,2).
- R5: In full-page mode the column increments modulo 256 with no end, and `last_beat` never asserts.
- R6: Key bits [6:4] = 2 or 3 set read latency L. For a read command sampled in cycle 0, `rd_dvalid` is high in cycles L through L+B−1 for a burst of B beats.
- R7: With key bit 9 = 1, write bursts are one beat long, while read bursts keep the programmed length.
- R8: `rd_hiz` equals `rmask_in` as sampled two cycles earlier. `wr_strobe` is high exactly on active write beats whose `wmask_in` is low in that same cycle.
- R9: `cmd_stop` ends the burst after the current beat. A new read or write command restarts the sequence at its own start column. Both rules hold in every mode.
- R10: `last_beat` is high on the final beat of a fixed-length burst, and `col_vld` drops in the following cycle unless a new command arrives.
- R11: A key with a reserved length code (4, 5 or 6), a latency code other than 2 or 3, full page with interleave, or nonzero bits [8:7] raises `mode_err` for one cycle and leaves the mode unchanged.
- R12: The first beat appears in the cycle after the command, with `col_out` equal to `start_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode-key write strobe |
| mode_key | input | 10 | Mode key: [2:0] length, [3] order, [6:4] latency, [8:7] must be 0, [9] single-beat write |
| mode_err | output | 1 | Refused mode key, one-cycle pulse |
| cmd_rd | input | 1 | Read burst command |
| cmd_wr | input | 1 | Write burst command |
| cmd_stop | input | 1 | Burst stop |
| start_col | input | COL_W | Start column of the command |
| rmask_in | input | 1 | Read output mask |
| wmask_in | input | 1 | Write data mask |
| col_out | output | COL_W | Column of the current beat |
| col_vld | output | 1 | A burst beat is presented |
| last_beat | output | 1 | Final beat of a fixed-length burst |
| burst_is_wr | output | 1 | Current burst is a write |
| wr_strobe | output | 1 | Unmasked write beat |
| rd_dvalid | output | 1 | Read data valid, latency-delayed |
| rd_hiz | output | 1 | Read output masked, two-cycle delayed |

## Verification
The assertions assume that `cmd_rd` and `cmd_wr` are never raised together. They also assume that `mode_wr` arrives only while no burst is active and no command is raised in the same cycle. The stimulus keeps to this by issuing mode writes only after the reference model reports the sequencer idle. In the random phase it draws at most one command kind per cycle and blocks key writes while a burst runs. The masks are driven freely every cycle, because both mask paths are meant to hold under any pattern.

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [9:0]       mode_key,
  output logic             mode_err,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] start_col,
  input  logic             rmask_in,
  input  logic             wmask_in,
  output logic [COL_W-1:0] col_out,
  output logic             col_vld,
  output logic             last_beat,
  output logic             burst_is_wr,
  output logic             wr_strobe,
  output logic             rd_dvalid,
  output logic             rd_hiz
);
  localparam logic [2:0] LEN_FULL = 3'd7;
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  logic [2:0] len_q;
  logic       ilv_mode_q, cl3_q, wb1_q;

  logic [COL_W-1:0] base_q, idx_q, msk_q;
  logic             act_q, wr_q, full_q, ilv_q, clb_q;
  logic [1:0]       rb_sh, hz_sh;

  logic key_ok, go, one_wr;
  logic [COL_W-1:0] len_msk;

  assign key_ok = (mode_key[2:0] <= 3'd3 || mode_key[2:0] == LEN_FULL) &&
                  (mode_key[6:4] == 3'd2 || mode_key[6:4] == 3'd3) &&
                  !(mode_key[2:0] == LEN_FULL && mode_key[3]) &&
                  (mode_key[8:7] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0; ilv_mode_q <= 1'b0; cl3_q <= 1'b0; wb1_q <= 1'b0;
      mode_err <= 1'b0;
    end else begin
      mode_err <= mode_wr && !key_ok;
      if (mode_wr && key_ok) begin
        len_q      <= mode_key[2:0];
        ilv_mode_q <= mode_key[3];
        cl3_q      <= mode_key[6:4] == 3'd3;
        wb1_q      <= mode_key[9];
      end
    end
  end

  assign go      = cmd_rd | cmd_wr;
  assign one_wr  = cmd_wr && wb1_q;
  assign len_msk = (len_q == LEN_FULL) ? ALL_ONES : COL_W'((1 << len_q) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0; idx_q <= '0; msk_q <= '0;
      act_q <= 1'b0; wr_q <= 1'b0; full_q <= 1'b0; ilv_q <= 1'b0; clb_q <= 1'b0;
    end else if (go) begin
      base_q <= start_col;
      idx_q  <= '0;
      msk_q  <= one_wr ? '0 : len_msk;
      full_q <= (len_q == LEN_FULL) && !one_wr;
      ilv_q  <= ilv_mode_q;
      wr_q   <= cmd_wr;
      act_q  <= 1'b1;
      if (cmd_rd) clb_q <= cl3_q;
    end else if (cmd_stop) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (!full_q && idx_q == msk_q) act_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign col_out = ilv_q ? (base_q ^ idx_q)
                         : ((base_q & ~msk_q) | ((base_q + idx_q) & msk_q));
  assign col_vld     = act_q;
  assign last_beat   = act_q && !full_q && idx_q == msk_q;
  assign burst_is_wr = act_q && wr_q;
  assign wr_strobe   = act_q && wr_q && !wmask_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_sh <= '0;
      hz_sh <= '0;
    end else begin
      rb_sh <= {rb_sh[0], act_q && !wr_q};
      hz_sh <= {hz_sh[0], rmask_in};
    end
  end

  assign rd_dvalid = clb_q ? rb_sh[1] : rb_sh[0];
  assign rd_hiz    = hz_sh[1];
endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr,
  input logic             mode_err,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic             cmd_stop,
  input logic [COL_W-1:0] start_col,
  input logic             rmask_in,
  input logic             wmask_in,
  input logic [COL_W-1:0] col_out,
  input logic             col_vld,
  input logic             last_beat,
  input logic             wr_strobe,
  input logic             rd_hiz
);
  // R12
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd || cmd_wr) |=> (col_vld && col_out == $past(start_col)));
  // R9
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && !cmd_rd && !cmd_wr) |=> !col_vld);
  // R10
  last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_vld);
  // R10
  last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !cmd_rd && !cmd_wr) |=> !col_vld);
  // R8
  rmask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rmask_in |-> ##2 rd_hiz);
  // R8
  rmask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rmask_in |-> ##2 !rd_hiz);
  // R8
  wmask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (!wmask_in && col_vld));
  // R11
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> $past(mode_wr));
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_err(mode_err),
  .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_stop(cmd_stop), .start_col(start_col),
  .rmask_in(rmask_in), .wmask_in(wmask_in), .col_out(col_out), .col_vld(col_vld),
  .last_beat(last_beat), .wr_strobe(wr_strobe), .rd_hiz(rd_hiz)
);

// File: tb/sdram_col_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_col_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [9:0] mode_key = '0;
  logic cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_stop = 1'b0;
  logic [7:0] start_col = '0;
  logic rmask_in = 1'b0, wmask_in = 1'b0;
  logic mode_err, col_vld, last_beat, burst_is_wr, wr_strobe, rd_dvalid, rd_hiz;
  logic [7:0] col_out;

  always #10 clk = ~clk;

  sdram_col_seq #(.COL_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_key(mode_key), .mode_err(mode_err),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_stop(cmd_stop), .start_col(start_col),
    .rmask_in(rmask_in), .wmask_in(wmask_in), .col_out(col_out), .col_vld(col_vld),
    .last_beat(last_beat), .burst_is_wr(burst_is_wr), .wr_strobe(wr_strobe),
    .rd_dvalid(rd_dvalid), .rd_hiz(rd_hiz)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string req = "R1";

  // reference model state
  int m_blc, m_bt, m_cl, m_wb, m_err;
  int b_act, b_start, b_idx, b_len, b_full, b_wr, b_ilv, b_cl;
  int h0, h1, k0, k1;

  function automatic bit key_valid(logic [9:0] k);
    int lc = k[2:0];
    return (lc <= 3 || lc == 7) && (k[6:4] == 2 || k[6:4] == 3) &&
           !(lc == 7 && k[3]) && k[8:7] == 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_blc = 0; m_bt = 0; m_cl = 2; m_wb = 0; m_err = 0;
      b_act = 0; b_start = 0; b_idx = 0; b_len = 1; b_full = 0; b_wr = 0; b_ilv = 0; b_cl = 2;
      h0 = 0; h1 = 0; k0 = 0; k1 = 0;
    end else begin
      h1 = h0; h0 = (b_act && !b_wr) ? 1 : 0;
      k1 = k0; k0 = rmask_in;
      m_err = 0;
      if (mode_wr) begin
        if (key_valid(mode_key)) begin
          m_blc = mode_key[2:0]; m_bt = mode_key[3]; m_cl = mode_key[6:4]; m_wb = mode_key[9];
        end else m_err = 1;
      end
      if (cmd_rd || cmd_wr) begin
        b_act = 1; b_start = start_col; b_idx = 0; b_wr = cmd_wr; b_ilv = m_bt;
        if (cmd_wr && m_wb) b_len = 1;
        else b_len = (m_blc == 7) ? 256 : (1 << m_blc);
        b_full = (b_len == 256);
        if (cmd_rd) b_cl = m_cl;
      end else if (cmd_stop) begin
        b_act = 0;
      end else if (b_act) begin
        if (!b_full && b_idx == b_len - 1) b_act = 0;
        b_idx = (b_idx + 1) % 256;
      end
    end
  end

  function automatic int exp_col();
    if (b_ilv) return b_start ^ b_idx;
    if (b_full) return (b_start + b_idx) % 256;
    return (b_start / b_len) * b_len + ((b_start % b_len) + b_idx) % b_len;
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("col_vld", col_vld, b_act);
    if (b_act) begin
      chk("col_out", col_out, exp_col());
      chk("burst_is_wr", burst_is_wr, b_wr);
    end
    chk("last_beat", last_beat, (b_act && !b_full && b_idx == b_len - 1) ? 1 : 0);
    chk("wr_strobe", wr_strobe, (b_act && b_wr && !wmask_in) ? 1 : 0);
    chk("rd_dvalid", rd_dvalid, (b_cl == 3) ? h1 : h0);
    chk("rd_hiz", rd_hiz, k1);
    chk("mode_err", mode_err, m_err);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    cmd_rd = 0; cmd_wr = 0; cmd_stop = 0; mode_wr = 0;
    rmask_in = $urandom_range(0, 1);
    wmask_in = $urandom_range(0, 1);
  endtask

  task automatic idle();
    while (b_act) tick();
    tick(); tick(); tick();
  endtask

  task automatic set_mode(logic [9:0] k);
    mode_wr = 1; mode_key = k; tick();
  endtask

  task automatic rd(int c);
    cmd_rd = 1; start_col = c[7:0]; tick();
  endtask

  task automatic wr(int c);
    cmd_wr = 1; start_col = c[7:0]; tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1"; tick();
    rd(8'h37); idle();              // R1 default length 1, latency 2
    req = "R3"; set_mode(10'b0_00_010_0_010); // length 4, linear, latency 2
    rd(2); idle(); rd(8'hFE); idle();
    req = "R2"; set_mode(10'b0_00_010_0_001); // length 2
    wr(8'h81); idle(); rd(8'h40); idle();
    req = "R4"; set_mode(10'b0_00_011_1_011); // length 8, interleave, latency 3
    rd(5); idle();
    req = "R6"; rd(8'h13); idle();
    req = "R11"; set_mode(10'b0_00_010_0_100); idle(); rd(8'h22); idle();
    set_mode(10'b0_00_001_0_010); idle(); rd(8'h23); idle();
    set_mode(10'b0_00_010_1_111); idle();
    set_mode(10'b0_01_010_0_010); idle(); rd(8'h24); idle();
    req = "R5"; set_mode(10'b0_00_010_0_111);  // full page linear
    rd(8'hF0); repeat (300) tick(); cmd_stop = 1; tick(); idle();
    req = "R7"; set_mode(10'b1_00_011_0_011);  // length 8, single write
    wr(8'h55); idle(); rd(8'h55); idle();
    req = "R9"; set_mode(10'b0_00_010_0_011);
    rd(0); tick(); tick(); rd(8'h20); tick(); wr(8'h44); tick(); cmd_stop = 1; tick(); idle();
    req = "R10"; set_mode(10'b0_00_011_0_010);
    rd(8'h0C); tick(); tick(); tick(); rd(8'h09); idle();
    req = "R12";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 19);
      if (r == 0 && !b_act) begin
        logic [9:0] k = 10'($urandom_range(0, 1023));
        k[8:7] = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
        mode_wr = 1; mode_key = k;
      end else if (r < 3) begin
        cmd_rd = 1; start_col = 8'($urandom_range(0, 255));
      end else if (r < 5) begin
        cmd_wr = 1; start_col = 8'($urandom_range(0, 255));
      end else if (r == 5) cmd_stop = 1;
      tick();
    end
    req = "R8"; idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog %s run did not finish", req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule